// File: doc/BRIEF.md
# Three-Byte Serial Register Slave

This block is a register-access target for a single-master, two-wire style serial bus. The usual shared data wire is split into two one-way lines: an inbound line carrying master-to-slave data and an outbound line carrying slave-to-master data. This makes the block suitable for a differential physical layer. Both bus inputs are sampled by a fast system clock through a two-flop synchronizer. START and STOP are recognised as edges on the inbound line while the clock line is high. The slave never holds the clock low, and it has no arbitration logic.

Every transaction is framed as three bytes. The first byte is a header: bits [7:4] hold the chip identifier, bits [3:1] hold the page, and bit 0 is the direction flag, where 1 means read. The second byte is the register address. The third byte is the write data sent by the master, or, for a read, the register contents shifted out by the slave. Register storage is kept in three copies and read back through a bitwise majority vote. The voted contents also drive the configuration output.

There is no dedicated reset pin at the bus. Two events clear the block:
- A synchronous fast-command reset pulse clears everything.
- Holding the clock line and the inbound line both low for a fixed number of system clocks returns the framing logic to idle. This does not touch the registers.

Top module: `tribyte_reg_slave`

## Requirements
- R1: While and after the fast-command reset `rst`, the outbound line is high and every configuration register reads 0x00.
- R2: A write with a matching identifier stores its third byte in register `page*WIN_REGS + address`, and the value appears in `cfg_flat` bits [8*index+7 : 8*index].
- R3: For an accepted write, the slave pulls the outbound line low during the ninth SCL-high phase of each of the three bytes. For an accepted read, it does so for the first two bytes. At all other times it drives low only while shifting read data.
- R4: When header bits [7:4] differ from `id_strap`, the outbound line stays high for the whole transaction and no register changes.
- R5: In a read, the slave shifts out the addressed register MSB first as the third byte. Each bit changes only while SCL is low and is valid during the following SCL-high phase.
- R6: A page at or above `WIN_PAGES`, or an address at or above `WIN_REGS`, is still acknowledged. A write to it changes no register, and a read from it returns 0x00.
- R7: Bytes after the third are not acknowledged and change nothing until the next START or STOP.
- R8: A repeated START at any point restarts framing at the header byte. A transaction cut short by a repeated START writes nothing.
- R9: SCL and the inbound line both low for `BUS_CLEAR_CYC` consecutive system clocks returns the framing logic to idle. Following bits are then ignored until a new START, and register contents are kept.
- R10: A fast-command reset pulse in the middle of a transaction aborts it, releases the outbound line and clears all registers.
- R11: Every write updates all three register copies, so the copies always agree, and the stored value is the bitwise majority of the three copies.
- R12: Between transactions, meaning after STOP and before START, the outbound line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high fast-command reset |
| id_strap | input | ID_W | Chip identifier this slave answers to |
| scl_in | input | 1 | Serial bus clock from the master |
| sda_m2s | input | 1 | Inbound data line, master to slave |
| sda_s2m | output | 1 | Outbound data line, slave to master, idle high |
| cfg_flat | output | WIN_PAGES*WIN_REGS*8 | Voted register contents, register i in bits [8i+7:8i] |

## Verification
The bench uses the default build: a 4-bit identifier, a 3-bit page field, a window of 2 pages of 8 registers, and a bus-clear threshold of 40 clocks. This keeps the register window at 16 entries, so every register can be written with an arithmetically derived value and read back. All 15 non-matching identifiers can also be swept. The 3-bit page field extends past the window, so out-of-window pages and addresses can be reached. The serial clock half-period is 6 system clocks, which keeps normal low overlaps far below the bus-clear threshold.

// File: rtl/tbrs_pkg.sv
package tbrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKP,
    ST_ACK,
    ST_TX,
    ST_TXEND,
    ST_DONE
  } tbrs_state_e;
endpackage

// File: rtl/tbrs_line_sync.sv
module tbrs_line_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic bus_clear
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;
  logic [CNT_W-1:0] low_cnt;
  logic both_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[SYNC_STAGES-1];
      sda_d    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign both_low  = ~scl_s & ~sda_s;

  // Saturating counter of cycles with both lines low; one pulse per hold.
  always_ff @(posedge clk) begin
    if (rst || !both_low) begin
      low_cnt <= '0;
    end else if (low_cnt != CNT_W'(HOLD_CYC)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign bus_clear = both_low && (low_cnt == CNT_W'(HOLD_CYC - 1));
endmodule

// File: rtl/tbrs_frame_fsm.sv
module tbrs_frame_fsm
  import tbrs_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int PAGE_W    = 3,
  parameter int WIN_PAGES = 2,
  parameter int WIN_REGS  = 8,
  parameter int IDX_W     = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ID_W-1:0]                 id_strap,
  input  logic                            sda_s,
  input  logic                            scl_rise,
  input  logic                            scl_fall,
  input  logic                            start_det,
  input  logic                            stop_det,
  input  logic                            bus_clear,
  input  logic [ID_W+PAGE_W:0]            rd_data,
  output logic                            sda_out,
  output logic                            wr_en,
  output logic [IDX_W-1:0]                wr_idx,
  output logic [ID_W+PAGE_W:0]            wr_data,
  output logic [IDX_W-1:0]                rd_idx,
  output logic                            rd_ok,
  output tbrs_state_e                     state_o
);
  localparam int BYTE_W = ID_W + PAGE_W + 1;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  tbrs_state_e       state;
  logic [BIT_W-1:0]  bit_cnt;
  logic [1:0]        byte_idx;
  logic [BYTE_W-1:0] shreg, tx_sh, next_byte, addr_q;
  logic [PAGE_W-1:0] page_q;
  logic              rw_q;
  logic              in_window;
  logic [IDX_W-1:0]  cur_idx;

  assign next_byte = {shreg[BYTE_W-2:0], sda_s};
  assign in_window = (32'(page_q) < WIN_PAGES) && (32'(addr_q) < WIN_REGS);
  assign cur_idx   = IDX_W'(32'(page_q) * WIN_REGS + 32'(addr_q));
  assign rd_idx    = cur_idx;
  assign rd_ok     = in_window;
  assign state_o   = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sda_out  <= 1'b1;
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      tx_sh    <= '0;
      addr_q   <= '0;
      page_q   <= '0;
      rw_q     <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_clear || stop_det) begin
        state   <= ST_IDLE;
        sda_out <= 1'b1;
      end else if (start_det) begin
        state    <= ST_RX;
        sda_out  <= 1'b1;
        bit_cnt  <= '0;
        byte_idx <= '0;
      end else begin
        unique case (state)
          ST_RX: if (scl_rise) begin
            shreg <= next_byte;
            if (bit_cnt == BIT_LAST) begin
              bit_cnt <= '0;
              case (byte_idx)
                2'd0: begin
                  if (next_byte[BYTE_W-1 -: ID_W] == id_strap) begin
                    page_q <= next_byte[PAGE_W:1];
                    rw_q   <= next_byte[0];
                    state  <= ST_ACKP;
                  end else begin
                    state <= ST_DONE;
                  end
                end
                2'd1: begin
                  addr_q <= next_byte;
                  state  <= ST_ACKP;
                end
                default: begin
                  wr_en   <= in_window;
                  wr_idx  <= cur_idx;
                  wr_data <= next_byte;
                  state   <= ST_ACKP;
                end
              endcase
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_ACKP: if (scl_fall) begin
            sda_out <= 1'b0;
            state   <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            if (byte_idx == 2'd2) begin
              sda_out <= 1'b1;
              state   <= ST_DONE;
            end else if (byte_idx == 2'd1 && rw_q) begin
              byte_idx <= 2'd2;
              state    <= ST_TX;
              sda_out  <= rd_data[BYTE_W-1];
              tx_sh    <= {rd_data[BYTE_W-2:0], 1'b0};
              bit_cnt  <= '0;
            end else begin
              byte_idx <= byte_idx + 1'b1;
              state    <= ST_RX;
              sda_out  <= 1'b1;
              bit_cnt  <= '0;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              if (bit_cnt == BIT_LAST) state <= ST_TXEND;
              else bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              sda_out <= tx_sh[BYTE_W-1];
              tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
          end
          ST_TXEND: if (scl_fall) begin
            sda_out <= 1'b1;
            state   <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tbrs_tmr_bank.sv
module tbrs_tmr_bank #(
  parameter int          DW      = 8,
  parameter int          REGS    = 16,
  parameter int          IDX_W   = 4,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic                 rd_ok,
  output logic [DW-1:0]        rd_data,
  output logic [REGS*DW-1:0]   cfg_flat,
  output logic                 copy_mismatch
);
  localparam int COPIES = 3;
  localparam int FLAT_W = REGS * DW;

  logic [COPIES-1:0][FLAT_W-1:0] copies;
  logic [FLAT_W-1:0] voted;

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [FLAT_W-1:0] store_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        store_q <= {REGS{RST_VAL}};
      end else if (wr_en) begin
        store_q[wr_idx*DW +: DW] <= wr_data;
      end
    end
    assign copies[c] = store_q;
  end

  assign voted = (copies[0] & copies[1]) | (copies[0] & copies[2]) |
                 (copies[1] & copies[2]);
  assign copy_mismatch = |((copies[0] ^ copies[1]) | (copies[0] ^ copies[2]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_flat <= {REGS{RST_VAL}};
      rd_data  <= '0;
    end else begin
      cfg_flat <= voted;
      rd_data  <= rd_ok ? voted[rd_idx*DW +: DW] : '0;
    end
  end
endmodule

// File: rtl/tribyte_reg_slave.sv
module tribyte_reg_slave
  import tbrs_pkg::*;
#(
  parameter int ID_W          = 4,
  parameter int PAGE_W        = 3,
  parameter int WIN_PAGES     = 2,
  parameter int WIN_REGS      = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int BUS_CLEAR_CYC = 40,
  parameter logic [ID_W+PAGE_W:0] RST_VAL = '0
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic [ID_W-1:0]                              id_strap,
  input  logic                                         scl_in,
  input  logic                                         sda_m2s,
  output logic                                         sda_s2m,
  output logic [WIN_PAGES*WIN_REGS*(ID_W+PAGE_W+1)-1:0] cfg_flat
);
  localparam int BYTE_W = ID_W + PAGE_W + 1;
  localparam int REGS   = WIN_PAGES * WIN_REGS;
  localparam int IDX_W  = (REGS > 1) ? $clog2(REGS) : 1;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det, bus_clear;
  logic wr_en, rd_ok, copy_mismatch;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;
  tbrs_state_e fsm_state;

  tbrs_line_sync #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_CYC   (BUS_CLEAR_CYC)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_m2s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .bus_clear(bus_clear)
  );

  tbrs_frame_fsm #(
    .ID_W     (ID_W),
    .PAGE_W   (PAGE_W),
    .WIN_PAGES(WIN_PAGES),
    .WIN_REGS (WIN_REGS),
    .IDX_W    (IDX_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .id_strap (id_strap),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .bus_clear(bus_clear),
    .rd_data  (rd_data),
    .sda_out  (sda_s2m),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_ok    (rd_ok),
    .state_o  (fsm_state)
  );

  tbrs_tmr_bank #(
    .DW     (BYTE_W),
    .REGS   (REGS),
    .IDX_W  (IDX_W),
    .RST_VAL(RST_VAL)
  ) u_bank (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .rd_idx       (rd_idx),
    .rd_ok        (rd_ok),
    .rd_data      (rd_data),
    .cfg_flat     (cfg_flat),
    .copy_mismatch(copy_mismatch)
  );
endmodule

// File: rtl/tbrs_checker.sv
module tbrs_checker
  import tbrs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int REGS  = 16,
  parameter int IDX_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                scl_in,
  input logic                sda_s2m,
  input tbrs_state_e         state,
  input logic                wr_en,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [DW-1:0]       wr_data,
  input logic [REGS*DW-1:0]  cfg_flat,
  input logic                copy_mismatch,
  input logic                bus_clear,
  input logic                stop_det
);
  logic [1:0]       wr_pipe;
  logic [IDX_W-1:0] idx_d1, idx_d2;
  logic [DW-1:0]    dat_d1, dat_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pipe <= '0;
      idx_d1 <= '0; idx_d2 <= '0;
      dat_d1 <= '0; dat_d2 <= '0;
    end else begin
      wr_pipe <= {wr_pipe[0], wr_en};
      idx_d1 <= wr_idx; idx_d2 <= idx_d1;
      dat_d1 <= wr_data; dat_d2 <= dat_d1;
    end
  end

  // R2: a write strobe reaches the voted configuration output two cycles later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    wr_pipe[1] |-> (cfg_flat[idx_d2*DW +: DW] == dat_d2));

  // R11: the three copies never diverge
  p_copies_agree_r11: assert property (@(posedge clk) disable iff (rst)
    !copy_mismatch);

  // R12: outbound line released whenever framing is idle
  p_idle_release_r12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> sda_s2m);

  // R3: outbound line low only in an ack slot or while shifting read data
  p_low_in_slot_r3: assert property (@(posedge clk) disable iff (rst)
    !sda_s2m |-> (state == ST_ACK || state == ST_TX || state == ST_TXEND));

  // R5: outbound line changes only while the bus clock is low
  p_change_scl_low_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_s2m) |-> !scl_in);

  // R9: a bus-clear hold returns framing to idle
  p_bus_clear_idle_r9: assert property (@(posedge clk) disable iff (rst)
    bus_clear |=> (state == ST_IDLE));

  // R12: STOP returns framing to idle
  p_stop_idle_r12: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE));
endmodule

bind tribyte_reg_slave tbrs_checker #(
  .DW   (BYTE_W),
  .REGS (REGS),
  .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .scl_in       (scl_in),
  .sda_s2m      (sda_s2m),
  .state        (fsm_state),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .wr_data      (wr_data),
  .cfg_flat     (cfg_flat),
  .copy_mismatch(copy_mismatch),
  .bus_clear    (bus_clear),
  .stop_det     (stop_det)
);

// File: tb/tribyte_reg_slave_tb_top.sv
module tribyte_reg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;   // system clocks per SCL half period
  localparam int NREG       = 16;
  localparam logic [3:0] STRAP = 4'hA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic s2m;
  logic [NREG*8-1:0] cfg;
  logic [7:0] model [NREG];

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tribyte_reg_slave dut_i (
    .clk     (clk),
    .rst     (rst),
    .id_strap(STRAP),
    .scl_in  (scl),
    .sda_m2s (sda),
    .sda_s2m (s2m),
    .cfg_flat(cfg)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < NREG; i++) chk(req, 32'(cfg[i*8 +: 8]), 32'(model[i]));
  endtask

  task automatic send_bit(input logic b, output logic seen);
    scl = 1'b0; tick(H/2);
    sda = b;    tick(H - H/2);
    scl = 1'b1; tick(H/2);
    seen = s2m; tick(H - H/2);
  endtask

  task automatic bus_start();
    scl = 1'b0; tick(H/2);
    sda = 1'b1; tick(H - H/2);
    scl = 1'b1; tick(H);
    sda = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    scl = 1'b0; tick(H/2);
    sda = 1'b0; tick(H - H/2);
    scl = 1'b1; tick(H);
    sda = 1'b1; tick(H);
    tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(b[i], s);
    send_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      send_bit(1'b1, s);
      d = {d[6:0], s};
    end
    send_bit(1'b1, s);
  endtask

  task automatic write_txn(input logic [3:0] id, input logic [2:0] pg,
                           input logic [7:0] ad, input logic [7:0] dt,
                           output logic [2:0] a);
    bus_start();
    send_byte({id, pg, 1'b0}, a[0]);
    send_byte(ad, a[1]);
    send_byte(dt, a[2]);
    bus_stop();
  endtask

  task automatic read_txn(input logic [3:0] id, input logic [2:0] pg,
                          input logic [7:0] ad, output logic [7:0] d,
                          output logic [1:0] a);
    bus_start();
    send_byte({id, pg, 1'b1}, a[0]);
    send_byte(ad, a[1]);
    recv_byte(d);
    bus_stop();
  endtask

  initial begin
    logic [2:0] a3;
    logic [1:0] a2;
    logic [7:0] rd;
    logic       ax;

    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    tick(5);
    // R1: outputs during reset
    chk("R1 s2m in reset", 32'(s2m), 32'd1);
    rst = 1'b0;
    tick(5);
    chk("R1 s2m after reset", 32'(s2m), 32'd1);
    chk_all("R1 registers cleared");

    // R2/R3: write every window register with a computed value
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] v;
      v = 8'((i * 29 + 7) & 8'hFF);
      write_txn(STRAP, 3'(i / 8), 8'(i % 8), v, a3);
      model[i] = v;
      chk("R3 write acks", 32'(a3), 32'h7);
      chk("R12 s2m idle after stop", 32'(s2m), 32'd1);
    end
    chk_all("R2 R11 register contents");

    // R5/R11: read every register back
    for (int i = 0; i < NREG; i++) begin
      read_txn(STRAP, 3'(i / 8), 8'(i % 8), rd, a2);
      chk("R3 read acks", 32'(a2), 32'h3);
      chk("R5 R11 read data", 32'(rd), 32'(model[i]));
    end

    // R6: out-of-window pages and addresses
    for (int p = 2; p < 8; p++) begin
      write_txn(STRAP, 3'(p), 8'd1, 8'hE1, a3);
      chk("R6 ack out of window", 32'(a3), 32'h7);
      read_txn(STRAP, 3'(p), 8'd1, rd, a2);
      chk("R6 read zero", 32'(rd), 32'h0);
    end
    write_txn(STRAP, 3'd0, 8'd8, 8'hE2, a3);
    write_txn(STRAP, 3'd1, 8'hFF, 8'hE3, a3);
    read_txn(STRAP, 3'd0, 8'd200, rd, a2);
    chk("R6 read zero addr", 32'(rd), 32'h0);
    chk_all("R6 no register changed");

    // R4: every non-matching identifier
    for (int id = 0; id < 16; id++) begin
      if (4'(id) != STRAP) begin
        write_txn(4'(id), 3'd0, 8'd0, 8'h5A, a3);
        chk("R4 no ack write", 32'(a3), 32'h0);
        read_txn(4'(id), 3'd0, 8'd0, rd, a2);
        chk("R4 silent read", 32'(rd), 32'hFF);
      end
    end
    chk_all("R4 registers unchanged");

    // R7: fourth byte ignored
    bus_start();
    send_byte({STRAP, 3'd0, 1'b0}, a3[0]);
    send_byte(8'd2, a3[1]);
    send_byte(8'h3C, a3[2]);
    send_byte(8'hC3, ax);
    bus_stop();
    model[2] = 8'h3C;
    chk("R7 three acks", 32'(a3), 32'h7);
    chk("R7 fourth byte no ack", 32'(ax), 32'd0);
    chk_all("R7 contents");

    // R8: repeated START aborts pending write and reframes
    bus_start();
    send_byte({STRAP, 3'd0, 1'b0}, a3[0]);
    send_byte(8'd3, a3[1]);
    bus_start();
    send_byte({STRAP, 3'd0, 1'b0}, a3[0]);
    send_byte(8'd4, a3[1]);
    send_byte(8'h99, a3[2]);
    bus_stop();
    model[4] = 8'h99;
    chk("R8 acks after restart", 32'(a3), 32'h7);
    chk_all("R8 contents");

    // R9: bus clear mid-transaction
    bus_start();
    send_byte({STRAP, 3'd0, 1'b0}, a3[0]);
    send_byte(8'd5, a3[1]);
    scl = 1'b0; tick(H/2);
    sda = 1'b0; tick(60);
    send_byte(8'h77, ax);
    bus_stop();
    chk("R9 no ack after clear", 32'(ax), 32'd0);
    chk_all("R9 contents kept");
    write_txn(STRAP, 3'd0, 8'd5, 8'h66, a3);
    model[5] = 8'h66;
    chk("R9 recovers acks", 32'(a3), 32'h7);
    chk_all("R9 contents after recovery");

    // R10: fast reset mid-transaction
    bus_start();
    send_byte({STRAP, 3'd1, 1'b0}, a3[0]);
    scl = 1'b0; tick(2);
    rst = 1'b1; tick(3);
    rst = 1'b0; tick(3);
    chk("R10 s2m released", 32'(s2m), 32'd1);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    chk_all("R10 registers cleared");
    bus_stop();
    write_txn(STRAP, 3'd1, 8'd7, 8'hB4, a3);
    model[15] = 8'hB4;
    chk("R10 acks after reset", 32'(a3), 32'h7);
    read_txn(STRAP, 3'd1, 8'd7, rd, a2);
    chk("R10 R11 readback", 32'(rd), 32'hB4);
    chk_all("R10 contents");

    finish_run();
  end
endmodule